// File: doc/BRIEF.md
# Comparator edge interrupt controller

This block sits between an external voltage comparator and a processor core. It takes the comparator's one-bit result and passes it through a synchronizer. The synchronized level is shown in a single 8-bit control and status register. The block watches that level for a rising edge, a falling edge or any change, as software selects. A selected edge sets a sticky interrupt flag. An interrupt request is raised while the flag, a local enable bit and the core's global interrupt enable are all set.

Software clears the flag in one of two ways: by writing a one to the flag bit, or through the acknowledge strobe the core pulses when it takes the interrupt vector. Because clearing is by writing a one, a read-modify-write of the register while the flag is set writes the one back and clears the flag. A disable bit powers the comparator down. While this bit is set the level reads as zero, and turning the bit on or off never produces an edge event.

Register layout, where writes take effect on the clock edge that samples `wr_en`:
- bit 7: disable
- bit 6: reserved
- bit 5: comparator level (read-only)
- bit 4: flag
- bit 3: local enable
- bit 2: reserved
- bits 1:0: edge mode

Top module: `cmp_edge_irq`

## Requirements
- R1: After synchronous reset, `rd_data` reads 8'h00 and `irq` is 0.
- R2: Bit 5 of `rd_data` shows the value `cmp_in` had two clock edges earlier while bit 7 is 0; writes to bit 5 have no effect.
- R3: Bits 6 and 2 always read 0 whatever is written, and bits 7, 3 and 1:0 read back the value last written to them.
- R4: With mode 2'b00 the flag (bit 4) becomes 1 on the clock edge after bit 5 changes in either direction.
- R5: With mode 2'b11 only a 0-to-1 change of bit 5 sets the flag, and with mode 2'b10 only a 1-to-0 change does.
- R6: With mode 2'b01 no change of bit 5 sets the flag.
- R7: A write with bit 4 = 1 clears the flag, and a write with bit 4 = 0 leaves it unchanged.
- R8: A one-cycle pulse on `irq_ack` clears the flag on that clock edge.
- R9: `irq` equals flag AND bit 3 AND `glob_ie` at all times.
- R10: While bit 7 is 1, bit 5 reads 0 and no edge sets the flag. Setting or clearing bit 7 sets no flag, including in the cycle after the change.
- R11: When an edge event and a clear (write-one or acknowledge) fall on the same clock edge, the flag ends up 1.
- R12: Writing back a value read while the flag is set clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| cmp_in | input | 1 | Asynchronous comparator result |
| glob_ie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 1 | Vector-taken acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong previous-level register or a wrong mode decode shows up on the next clock edge as a flag bit that is wrong compared with the input history, and `irq` shows it in the same cycle. A synchronizer of the wrong depth makes bit 5 lead or lag the input by a cycle, and every input change exposes it. The bench compares every port field with a cycle-accurate model on each cycle, so a fault becomes visible on the first edge at which it changes an output. Mistakes in the suppression around the disable bit show only when the comparator is high and the disable bit is toggled, so the bench drives that case on purpose.

// File: rtl/cmp_edge_irq_pkg.sv
package cmp_edge_irq_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_OFF   = 7;
    localparam int BIT_RSV_H = 6;
    localparam int BIT_LVL   = 5;
    localparam int BIT_FLAG  = 4;
    localparam int BIT_IE    = 3;
    localparam int BIT_RSV_L = 2;
    localparam int MODE_LSB  = 0;
    localparam int MODE_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        EDGE_ANY  = 2'b00,
        EDGE_NONE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_RISE = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic       off;
        logic       ie;
        edge_mode_e mode;
    } ctrl_t;

    // Decide whether a level transition matches the selected mode.
    function automatic logic edge_match(input edge_mode_e mode,
                                        input logic prev_lvl,
                                        input logic cur_lvl);
        logic m;
        unique case (mode)
            EDGE_ANY:  m = prev_lvl ^ cur_lvl;
            EDGE_FALL: m = prev_lvl & ~cur_lvl;
            EDGE_RISE: m = ~prev_lvl & cur_lvl;
            default:   m = 1'b0;
        endcase
        return m;
    endfunction

    // Assemble the status/control read value; reserved bits stay zero.
    function automatic logic [REG_W-1:0] pack_status(input ctrl_t c,
                                                     input logic lvl,
                                                     input logic flag);
        logic [REG_W-1:0] v;
        v                          = '0;
        v[BIT_OFF]                 = c.off;
        v[BIT_LVL]                 = lvl;
        v[BIT_FLAG]                = flag;
        v[BIT_IE]                  = c.ie;
        v[MODE_LSB +: MODE_W]      = c.mode;
        return v;
    endfunction

    // Extract the writable control fields from a write value.
    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.off  = w[BIT_OFF];
        c.ie   = w[BIT_IE];
        c.mode = edge_mode_e'(w[MODE_LSB +: MODE_W]);
        return c;
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic gate_off,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        genvar i;
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // The flops keep sampling while powered down; only the visible level is forced low.
    assign dout = gate_off ? 1'b0 : chain[LAST];

endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
    import cmp_edge_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  logic       off,
    input  edge_mode_e mode,
    output logic       hit
);
    logic prev_lvl;
    logic off_q;
    logic quiet;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= 1'b0;
            off_q    <= 1'b0;
        end else begin
            prev_lvl <= level;
            off_q    <= off;
        end
    end

    // Blank events while off and in the cycle after the off bit changes state.
    assign quiet = off | off_q;
    assign hit   = ~quiet & edge_match(mode, prev_lvl, level);

endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
    import cmp_edge_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hit,
    input  logic             ack,
    output ctrl_t            ctrl,
    output logic             flag
);
    logic clr_req;
    logic unused_wr_bits;

    assign clr_req        = (wr_en & wr_data[BIT_FLAG]) | ack;
    assign unused_wr_bits = ^{wr_data[BIT_RSV_H], wr_data[BIT_LVL], wr_data[BIT_RSV_L]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{off: 1'b0, ie: 1'b0, mode: EDGE_ANY};
        end else if (wr_en) begin
            ctrl <= unpack_ctrl(wr_data);
        end
    end

    // Set has priority over either clear source.
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (hit)     flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq
    import cmp_edge_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             cmp_in,
    input  logic             glob_ie,
    input  logic             irq_ack,
    output logic             irq
);
    ctrl_t ctrl;
    logic  level;
    logic  flag;
    logic  edge_hit;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (cmp_in),
        .gate_off (ctrl.off),
        .dout     (level)
    );

    cmp_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .off   (ctrl.off),
        .mode  (ctrl.mode),
        .hit   (edge_hit)
    );

    cmp_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .hit     (edge_hit),
        .ack     (irq_ack),
        .ctrl    (ctrl),
        .flag    (flag)
    );

    assign rd_data = pack_status(ctrl, level, flag);
    assign irq     = flag & ctrl.ie & glob_ie;

endmodule

// File: rtl/cmp_edge_irq_chk.sv
module cmp_edge_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:2] rd_hi,
    input logic       irq,
    input logic       glob_ie,
    input logic       irq_ack,
    input logic       w1c,
    input logic       hit
);
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq == (rd_hi[4] & rd_hi[3] & glob_ie));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_hi[6] && !rd_hi[2]);

    a_r10_off_level_low: assert property (@(posedge clk) disable iff (rst)
        rd_hi[7] |-> !rd_hi[5]);

    a_r10_off_no_event: assert property (@(posedge clk) disable iff (rst)
        rd_hi[7] |-> !hit);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        hit |=> rd_hi[4]);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !hit) |=> !rd_hi[4]);

    a_r7_write_one_clears: assert property (@(posedge clk) disable iff (rst)
        (w1c && !hit) |=> !rd_hi[4]);

    a_r4_flag_from_event: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_hi[4]) |-> $past(hit));

endmodule

bind cmp_edge_irq cmp_edge_irq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_hi   (rd_data[7:2]),
    .irq     (irq),
    .glob_ie (glob_ie),
    .irq_ack (irq_ack),
    .w1c     (wr_en & wr_data[4]),
    .hit     (edge_hit)
);

// File: tb/cmp_edge_irq_test.sv
module cmp_edge_irq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cmp_in = 1'b0;
    logic       glob_ie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cmp_edge_irq uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cmp_in  (cmp_in),
        .glob_ie (glob_ie),
        .irq_ack (irq_ack),
        .irq     (irq)
    );

    // Reference model built from the requirements.
    logic       m_s1, m_s2, m_prev, m_offq, m_flag, m_off, m_ie;
    logic [1:0] m_mode;

    function automatic logic mode_hit(input logic [1:0] md, input logic p, input logic c);
        case (md)
            2'b00:   return p ^ c;
            2'b10:   return p & ~c;
            2'b11:   return ~p & c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic m_level();
        return m_off ? 1'b0 : m_s2;
    endfunction

    function automatic logic [7:0] m_status();
        return {m_off, 1'b0, m_level(), m_flag, m_ie, 1'b0, m_mode};
    endfunction

    always @(posedge clk) begin
        logic ev;
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_offq <= 0;
            m_flag <= 0; m_off <= 0; m_ie <= 0; m_mode <= 2'b00;
        end else begin
            ev = !(m_off | m_offq) && mode_hit(m_mode, m_prev, m_level());
            m_s1   <= cmp_in;
            m_s2   <= m_s1;
            m_prev <= m_level();
            m_offq <= m_off;
            if (ev) m_flag <= 1'b1;
            else if ((wr_en && wr_data[4]) || irq_ack) m_flag <= 1'b0;
            if (wr_en) begin
                m_off  <= wr_data[7];
                m_ie   <= wr_data[3];
                m_mode <= wr_data[1:0];
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic compare_model();
        logic [7:0] e;
        e = m_status();
        check("R2 level bit", {7'd0, rd_data[5]}, {7'd0, e[5]});
        check("R4 flag bit", {7'd0, rd_data[4]}, {7'd0, e[4]});
        check("R3 control and reserved bits", rd_data & 8'hCF, e & 8'hCF);
        check("R9 irq", {7'd0, irq}, {7'd0, m_flag & m_ie & glob_ie});
    endtask

    // Drive one cycle of inputs, then sample at the following falling edge.
    task automatic cyc(input logic c, input logic w, input logic [7:0] d,
                       input logic a, input logic g);
        cmp_in = c; wr_en = w; wr_data = d; irq_ack = a; glob_ie = g;
        @(negedge clk);
        compare_model();
    endtask

    task automatic idle(input int n, input logic c, input logic g);
        for (int i = 0; i < n; i++) cyc(c, 1'b0, 8'h00, 1'b0, g);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1 reset rd_data", rd_data, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        rst = 1'b0;

        // Rise mode with enable; reserved bits and level bit written as ones.
        cyc(0, 1, 8'b0110_1111, 0, 1);
        check("R3 readback", rd_data, 8'b0000_1011);
        cyc(1, 0, 8'h00, 0, 1);
        check("R2 level after one edge", {7'd0, rd_data[5]}, 8'h00);
        cyc(1, 0, 8'h00, 0, 1);
        check("R2 level after two edges", {7'd0, rd_data[5]}, 8'h01);
        cyc(1, 0, 8'h00, 0, 1);
        check("R5 rise sets flag", {7'd0, rd_data[4]}, 8'h01);
        check("R9 irq raised", {7'd0, irq}, 8'h01);
        cyc(1, 0, 8'h00, 0, 0);
        check("R9 irq gated by global enable", {7'd0, irq}, 8'h00);

        // Read-modify-write with the flag set.
        cyc(1, 1, rd_data, 0, 1);
        check("R12 rmw clears flag", {7'd0, rd_data[4]}, 8'h00);

        // Fall in rise mode: no event.
        idle(4, 0, 1);
        check("R5 fall ignored in rise mode", {7'd0, rd_data[4]}, 8'h00);

        // Falling mode.
        cyc(0, 1, 8'b0000_1010, 0, 1);
        idle(4, 1, 1);
        check("R5 rise ignored in fall mode", {7'd0, rd_data[4]}, 8'h00);
        idle(4, 0, 1);
        check("R5 fall sets flag", {7'd0, rd_data[4]}, 8'h01);
        cyc(0, 0, 8'h00, 1, 1);
        check("R8 ack clears flag", {7'd0, rd_data[4]}, 8'h00);

        // Toggle mode; write-zero keeps flag, write-one clears it.
        cyc(0, 1, 8'b0000_1000, 0, 1);
        idle(4, 1, 1);
        check("R4 toggle rise", {7'd0, rd_data[4]}, 8'h01);
        cyc(1, 1, 8'b0000_1000, 0, 1);
        check("R7 write zero keeps flag", {7'd0, rd_data[4]}, 8'h01);
        cyc(1, 1, 8'b0001_1000, 0, 1);
        check("R7 write one clears flag", {7'd0, rd_data[4]}, 8'h00);
        idle(4, 0, 1);
        check("R4 toggle fall", {7'd0, rd_data[4]}, 8'h01);
        cyc(0, 1, 8'b0001_1000, 0, 1);

        // Set beats acknowledge on the same edge.
        cyc(1, 0, 8'h00, 0, 1);
        cyc(1, 0, 8'h00, 0, 1);
        cyc(1, 0, 8'h00, 1, 1);
        check("R11 set wins over ack", {7'd0, rd_data[4]}, 8'h01);
        cyc(1, 0, 8'h00, 1, 1);

        // No-event mode.
        cyc(1, 1, 8'b0000_1001, 0, 1);
        idle(3, 0, 1); idle(3, 1, 1); idle(3, 0, 1);
        check("R6 no events in mode 01", {7'd0, rd_data[4]}, 8'h00);

        // Disable with input high: entering and leaving must not set the flag.
        cyc(1, 1, 8'b0000_1000, 0, 1);
        idle(4, 1, 1);
        cyc(1, 1, 8'b0001_1000, 0, 1);
        cyc(1, 1, 8'b1000_1000, 0, 1);
        check("R10 level reads zero when off", {7'd0, rd_data[5]}, 8'h00);
        idle(3, 0, 1); idle(3, 1, 1);
        check("R10 no event while off", {7'd0, rd_data[4]}, 8'h00);
        cyc(1, 1, 8'b0000_1000, 0, 1);
        idle(4, 1, 1);
        check("R10 no event on re-enable", {7'd0, rd_data[4]}, 8'h00);
        check("R2 level back after re-enable", {7'd0, rd_data[5]}, 8'h01);

        // Constrained random phase with a fixed seed.
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            logic       c, w, a, g;
            logic [7:0] d;
            c = ($urandom % 4) != 0 ? cmp_in : ~cmp_in;
            w = ($urandom % 8) == 0;
            d = $urandom;
            if (($urandom % 4) != 0) d[7] = 1'b0;
            if (($urandom % 2) == 0) d = rd_data;
            a = ($urandom % 10) == 0;
            g = ($urandom % 5) != 0;
            cyc(c, w, d, a, g);
        end

        summary();
        $finish;
    end

endmodule